// File: doc/BRIEF.md
# Directory Coherence Controller

This block keeps one directory entry for each line of a shared, inclusive last-level cache. The entry records which of four private caches hold a copy of the line, and whether one of them holds it modified. The private caches send read-shared, read-exclusive and writeback requests. The controller looks up the entry and works out which caches must act. It sends each of those caches its own invalidate or fetch message, never a broadcast. It waits until every targeted cache has acknowledged. It then rewrites the entry and returns a grant to the requester.

The controller is the single ordering point for every line. One transaction runs at a time from acceptance to grant, so all writes to a line fall into one order.

Handshake rules:
- Requests and coherence messages use valid/ready.
- Grants also use valid/ready.
- A transfer happens on a rising edge where valid and ready are both high.
- The controller holds `req_ready` low for the whole of a transaction, which stalls any further request.
- Once `msg_valid` or `gnt_valid` is raised, it and its fields stay unchanged until the matching ready is seen.
- Acknowledgements arrive as single-cycle pulses on `ack_vld`, one bit per cache, and are always accepted.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every entry is empty (no holders, not modified), `req_ready` is 1, and `msg_valid` and `gnt_valid` are 0.
- R2: A read-shared request (`req_op`=0) to a line that is not modified sends no message. It is granted, and the requester is added as a holder.
- R3: A read-shared request to a modified line owned by another cache sends exactly one fetch message (`msg_op`=1) to the owner. Afterwards the owner and the requester both hold the line and it is no longer modified.
- R4: A read-exclusive request (`req_op`=1) sends one invalidate (`msg_op`=0) to each holder other than the requester, in ascending cache index. No message goes to the requester or to a non-holder. Afterwards only the requester holds the line, and it is modified.
- R5: A grant is raised only after every cache that was sent a message has pulsed its `ack_vld` bit. Pulses from caches with no outstanding message are ignored.
- R6: A writeback (`req_op`=2) from the owner of a modified line clears the modified flag and the owner's holder bit. A writeback from any other cache, and a request with `req_op`=3, send no message and leave the entry unchanged.
- R7: From the cycle after a request is accepted until its grant is taken, `req_ready` is 0.
- R8: While `msg_valid` or `gnt_valid` is high and its ready is low, the valid stays high and its fields stay stable.
- R9: A read-shared request from the cache that owns the line modified sends no message and leaves the entry unchanged.
- R10: Each accepted request produces exactly one grant, carrying its cache, operation code and line, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_cache | input | CW | Requesting cache index |
| req_op | input | 2 | 0 read-shared, 1 read-exclusive, 2 writeback, 3 no-op |
| req_line | input | LW | Line index |
| msg_valid | output | 1 | Coherence message valid |
| msg_ready | input | 1 | Message accepted by the network |
| msg_dest | output | CW | Target cache |
| msg_op | output | 1 | 0 invalidate, 1 fetch |
| msg_line | output | LW | Line of the message |
| ack_vld | input | NCACHE | Per-cache acknowledge pulse |
| gnt_valid | output | 1 | Grant valid |
| gnt_ready | input | 1 | Grant accepted |
| gnt_cache | output | CW | Cache being granted |
| gnt_op | output | 2 | Operation code being granted |
| gnt_line | output | LW | Line being granted |

## Verification
The assertions check the following on every cycle:
- Ready drops after each acceptance.
- Message and grant fields are held under back-pressure.
- No message ever targets the requester.
- Fetches occur only for read-shared requests.
- No grant appears while a sent message is still unacknowledged.
- Each grant echoes the accepted request.

Whether the right set of caches was targeted, and whether each entry was rewritten correctly, only shows across the bench's scenarios. A later request to the same line exposes the earlier update through the messages it triggers, for example a fetch that proves a line stayed modified. The bench also tests an ignored acknowledgement and the writeback and no-op paths that must leave an entry unchanged.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic [1:0] {
    OP_RD_SHR = 2'd0,
    OP_RD_EXC = 2'd1,
    OP_WBACK  = 2'd2,
    OP_NOP    = 2'd3
  } dir_op_e;

  typedef enum logic {
    MSG_INVAL = 1'b0,
    MSG_FETCH = 1'b1
  } dir_msg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_COMMIT,
    ST_GRANT
  } dir_state_e;

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
  parameter int NCACHE = 4,
  parameter int LINES  = 16,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LW-1:0]     rd_line,
  output logic [NCACHE-1:0] rd_pres,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [LW-1:0]     wr_line,
  input  logic [NCACHE-1:0] wr_pres,
  input  logic              wr_dirty
);

  logic [NCACHE-1:0] pres_q [LINES];
  logic [LINES-1:0]  dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) pres_q[i] <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      pres_q[wr_line]  <= wr_pres;
      dirty_q[wr_line] <= wr_dirty;
    end
  end

  assign rd_pres  = pres_q[rd_line];
  assign rd_dirty = dirty_q[rd_line];

endmodule

// File: rtl/coh_dir_msg_sched.sv
module coh_dir_msg_sched #(
  parameter int NCACHE = 4,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCACHE-1:0] load_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CW-1:0]     out_dest
);

  logic [NCACHE-1:0] pend_q;
  logic [NCACHE-1:0] pick_oh;

  // lowest pending index goes first
  assign pick_oh = pend_q & (~pend_q + NCACHE'(1));

  always_comb begin
    out_dest = '0;
    for (int i = NCACHE - 1; i >= 0; i--) begin
      if (pend_q[i]) out_dest = CW'(i);
    end
  end

  assign out_valid = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_q <= '0;
    else if (load)                 pend_q <= load_mask;
    else if (out_valid && out_ready) pend_q <= pend_q & ~pick_oh;
  end

endmodule

// File: rtl/coh_dir_ack_track.sv
module coh_dir_ack_track #(
  parameter int NCACHE = 4,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sent,
  input  logic [CW-1:0]     sent_dest,
  input  logic [NCACHE-1:0] ack_vld,
  output logic              busy
);

  logic [NCACHE-1:0] owed_q;
  logic [NCACHE-1:0] sent_oh;

  assign sent_oh = sent ? (NCACHE'(1) << sent_dest) : '0;

  // an acknowledge only retires a message already sent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= (owed_q & ~ack_vld) | sent_oh;
  end

  assign busy = |owed_q;

endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int LINES  = 16,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CW-1:0]     req_cache,
  input  logic [1:0]        req_op,
  input  logic [LW-1:0]     req_line,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [CW-1:0]     msg_dest,
  output logic              msg_op,
  output logic [LW-1:0]     msg_line,
  input  logic [NCACHE-1:0] ack_vld,
  output logic              gnt_valid,
  input  logic              gnt_ready,
  output logic [CW-1:0]     gnt_cache,
  output logic [1:0]        gnt_op,
  output logic [LW-1:0]     gnt_line
);

  dir_state_e        state_q, state_d;
  logic [CW-1:0]     cap_cache_q;
  dir_op_e           cap_op_q;
  logic [LW-1:0]     cap_line_q;
  logic [NCACHE-1:0] cap_pres_q;
  logic              cap_dirty_q;

  logic [NCACHE-1:0] rd_pres;
  logic              rd_dirty;
  logic [NCACHE-1:0] req_oh, cap_oh, tgt;
  logic [NCACHE-1:0] new_pres;
  logic              new_dirty, cap_own;
  logic              accept, sched_valid, ack_busy, wr_en;
  dir_op_e           in_op;

  assign in_op  = dir_op_e'(req_op);
  assign accept = req_valid && req_ready;
  assign req_oh = NCACHE'(1) << req_cache;
  assign cap_oh = NCACHE'(1) << cap_cache_q;
  assign wr_en  = (state_q == ST_COMMIT);

  coh_dir_store #(.NCACHE(NCACHE), .LINES(LINES)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_line  (req_line),
    .rd_pres  (rd_pres),
    .rd_dirty (rd_dirty),
    .wr_en    (wr_en),
    .wr_line  (cap_line_q),
    .wr_pres  (new_pres),
    .wr_dirty (new_dirty)
  );

  // caches that must act before the request can be granted
  always_comb begin
    tgt = '0;
    case (in_op)
      OP_RD_SHR: if (rd_dirty && !(|(rd_pres & req_oh))) tgt = rd_pres;
      OP_RD_EXC: tgt = rd_pres & ~req_oh;
      default:   tgt = '0;
    endcase
  end

  coh_dir_msg_sched #(.NCACHE(NCACHE)) sched_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_mask (tgt),
    .out_valid (sched_valid),
    .out_ready (msg_ready),
    .out_dest  (msg_dest)
  );

  coh_dir_ack_track #(.NCACHE(NCACHE)) acks_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sent      (sched_valid && msg_ready),
    .sent_dest (msg_dest),
    .ack_vld   (ack_vld),
    .busy      (ack_busy)
  );

  // entry contents written once all targeted caches have answered
  assign cap_own = cap_dirty_q && (|(cap_pres_q & cap_oh));

  always_comb begin
    new_pres  = cap_pres_q;
    new_dirty = cap_dirty_q;
    case (cap_op_q)
      OP_RD_SHR: if (!cap_own) begin
        new_pres  = cap_pres_q | cap_oh;
        new_dirty = 1'b0;
      end
      OP_RD_EXC: begin
        new_pres  = cap_oh;
        new_dirty = 1'b1;
      end
      OP_WBACK: if (cap_own) begin
        new_pres  = cap_pres_q & ~cap_oh;
        new_dirty = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = (|tgt) ? ST_XFER : ST_COMMIT;
      ST_XFER:   if (!sched_valid && !ack_busy) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_GRANT;
      ST_GRANT:  if (gnt_ready) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cap_cache_q <= '0;
      cap_op_q    <= OP_NOP;
      cap_line_q  <= '0;
      cap_pres_q  <= '0;
      cap_dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cap_cache_q <= req_cache;
        cap_op_q    <= in_op;
        cap_line_q  <= req_line;
        cap_pres_q  <= rd_pres;
        cap_dirty_q <= rd_dirty;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign msg_valid = sched_valid;
  assign msg_op    = (cap_op_q == OP_RD_SHR) ? MSG_FETCH : MSG_INVAL;
  assign msg_line  = cap_line_q;
  assign gnt_valid = (state_q == ST_GRANT);
  assign gnt_cache = cap_cache_q;
  assign gnt_op    = cap_op_q;
  assign gnt_line  = cap_line_q;

endmodule

// File: rtl/coh_dir_ctrl_chk.sv
module coh_dir_ctrl_chk #(
  parameter int NCACHE = 4,
  parameter int LINES  = 16,
  localparam int CW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CW-1:0]     req_cache,
  input logic [1:0]        req_op,
  input logic [LW-1:0]     req_line,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [CW-1:0]     msg_dest,
  input logic              msg_op,
  input logic [LW-1:0]     msg_line,
  input logic [NCACHE-1:0] ack_vld,
  input logic              gnt_valid,
  input logic              gnt_ready,
  input logic [CW-1:0]     gnt_cache,
  input logic [1:0]        gnt_op,
  input logic [LW-1:0]     gnt_line
);

  logic [CW-1:0]     seen_cache;
  logic [1:0]        seen_op;
  logic [LW-1:0]     seen_line;
  logic [NCACHE-1:0] unacked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_cache <= '0;
      seen_op    <= '0;
      seen_line  <= '0;
      unacked    <= '0;
    end else begin
      if (req_valid && req_ready) begin
        seen_cache <= req_cache;
        seen_op    <= req_op;
        seen_line  <= req_line;
      end
      unacked <= (unacked & ~ack_vld) |
                 ((msg_valid && msg_ready) ? (NCACHE'(1) << msg_dest) : '0);
    end
  end

  // R7
  ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dest) &&
                                   $stable(msg_op) && $stable(msg_line)));

  // R8
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_cache) &&
                                   $stable(gnt_op) && $stable(gnt_line)));

  // R4
  no_self_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dest != seen_cache));

  // R3
  fetch_on_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_op) |-> (seen_op == 2'd0));

  // R5
  acks_before_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (unacked == '0));

  // R10
  gnt_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_cache == seen_cache && gnt_op == seen_op &&
                   gnt_line == seen_line));

endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(.NCACHE(NCACHE), .LINES(LINES)) chk_i (.*);

// File: tb/coh_dir_ctrl_tb_top.sv
`timescale 1ns/1ps
module coh_dir_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_cache = '0;
  logic [1:0] req_op = '0;
  logic [3:0] req_line = '0;
  logic       msg_valid, msg_ready;
  logic [1:0] msg_dest;
  logic       msg_op;
  logic [3:0] msg_line;
  logic [3:0] ack_vld;
  logic       gnt_valid, gnt_ready;
  logic [1:0] gnt_cache, gnt_op;
  logic [3:0] gnt_line;

  always #4 clk = ~clk;

  coh_dir_ctrl #(.NCACHE(4), .LINES(16)) dut_i (.*);

  typedef struct packed { logic [1:0] dest; logic op; logic [3:0] line; logic [7:0] rq; } msg_t;
  typedef struct packed { logic [1:0] cache; logic [1:0] op; logic [3:0] line; logic [7:0] rq; } gnt_t;

  msg_t exp_msg[$];
  gnt_t exp_gnt[$];
  int   checks = 0, errors = 0;
  logic [3:0] m_pres [16];
  logic       m_dirty [16];
  int   timer [4];
  logic [3:0] owed = '0;
  logic [3:0] stray = '0;
  int   ack_base = 1;
  bit   stall = 0;
  bit   inflight = 0;
  int   cyc = 0;
  bit   mhold = 0, ghold = 0;
  logic [6:0] msave;
  logic [7:0] gsave;

  // responder: acknowledges, ready patterns, stray pulses
  initial begin
    ack_vld = '0; msg_ready = 1'b1; gnt_ready = 1'b1;
    for (int i = 0; i < 4; i++) timer[i] = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      for (int i = 0; i < 4; i++) begin
        ack_vld[i] = (timer[i] == 1) | stray[i];
        if (timer[i] > 0) timer[i]--;
      end
      stray = '0;
      msg_ready = stall ? (cyc % 3 != 0) : 1'b1;
      gnt_ready = stall ? (cyc % 2 == 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    // R7: no acceptance while a transaction is in flight
    if (inflight && req_ready) begin
      errors++; $display("FAIL R7 req_ready got 1 exp 0 during transaction");
    end
    // R8: held fields under back-pressure
    if (mhold) begin
      checks++;
      if (!msg_valid || {msg_dest, msg_op, msg_line} != msave) begin
        errors++; $display("FAIL R8 msg got %b/%h exp 1/%h", msg_valid, {msg_dest, msg_op, msg_line}, msave);
      end
    end
    if (ghold) begin
      checks++;
      if (!gnt_valid || {gnt_cache, gnt_op, gnt_line} != gsave) begin
        errors++; $display("FAIL R8 gnt got %b/%h exp 1/%h", gnt_valid, {gnt_cache, gnt_op, gnt_line}, gsave);
      end
    end
    mhold = msg_valid && !msg_ready; msave = {msg_dest, msg_op, msg_line};
    ghold = gnt_valid && !gnt_ready; gsave = {gnt_cache, gnt_op, gnt_line};

    if (gnt_valid && gnt_ready) begin
      gnt_t e;
      checks++;
      // R5: all messages acknowledged before the grant
      if (owed != '0) begin
        errors++; $display("FAIL R5 owed acks got %b exp 0000 at grant", owed);
      end
      if (exp_gnt.size() == 0) begin
        errors++; $display("FAIL R10 unexpected grant got %h exp none", {gnt_cache, gnt_op, gnt_line});
      end else begin
        e = exp_gnt.pop_front();
        if ({gnt_cache, gnt_op, gnt_line} != {e.cache, e.op, e.line}) begin
          errors++; $display("FAIL R%0d grant got c%0d op%0d l%0d exp c%0d op%0d l%0d",
                             e.rq, gnt_cache, gnt_op, gnt_line, e.cache, e.op, e.line);
        end
      end
      inflight = 0;
    end
    if (msg_valid && msg_ready) begin
      msg_t e;
      checks++;
      if (exp_msg.size() == 0) begin
        errors++; $display("FAIL R4 unexpected msg got d%0d op%0d l%0d exp none", msg_dest, msg_op, msg_line);
      end else begin
        e = exp_msg.pop_front();
        if ({msg_dest, msg_op, msg_line} != {e.dest, e.op, e.line}) begin
          errors++; $display("FAIL R%0d msg got d%0d op%0d l%0d exp d%0d op%0d l%0d",
                             e.rq, msg_dest, msg_op, msg_line, e.dest, e.op, e.line);
        end
      end
      owed[msg_dest] = 1'b1;
      timer[msg_dest] = ack_base + 32'(msg_dest);
    end
    owed = owed & ~ack_vld;
    if (req_valid && req_ready) inflight = 1;
  end

  // driver: model the directory from the requirements and queue expectations
  task automatic do_req(input int c, input int op, input int ln, input int rq);
    logic [3:0] rb, tgt, p;
    logic d, own;
    gnt_t g;
    rb = 4'(1 << c); p = m_pres[ln]; d = m_dirty[ln];
    own = d && ((p & rb) != 0);
    tgt = '0;
    if (op == 0 && d && !own) tgt = p;             // R3 fetch from owner
    if (op == 1) tgt = p & ~rb;                    // R4 invalidate others
    for (int i = 0; i < 4; i++)
      if (tgt[i]) exp_msg.push_back('{dest: 2'(i), op: (op == 0), line: 4'(ln), rq: 8'((op == 0) ? 3 : 4)});
    case (op)
      0: if (!own) begin m_pres[ln] = p | rb; m_dirty[ln] = 1'b0; end
      1: begin m_pres[ln] = rb; m_dirty[ln] = 1'b1; end
      2: if (own) begin m_pres[ln] = p & ~rb; m_dirty[ln] = 1'b0; end
      default: ;
    endcase
    g.cache = 2'(c); g.op = 2'(op); g.line = 4'(ln); g.rq = 8'(rq);
    exp_gnt.push_back(g);
    @(posedge clk); #1;
    req_valid = 1'b1; req_cache = 2'(c); req_op = 2'(op); req_line = 4'(ln);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!inflight && exp_gnt.size() == 0 && !req_valid) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin m_pres[i] = '0; m_dirty[i] = 1'b0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (!req_ready || msg_valid || gnt_valid) begin
      errors++; $display("FAIL R1 ready/msg/gnt got %b%b%b exp 100", req_ready, msg_valid, gnt_valid);
    end
    // R2 shared reads on a clean line
    do_req(0, 0, 3, 2); do_req(1, 0, 3, 2); do_req(2, 0, 3, 2);
    drain();
    // R4 exclusive read invalidates 0 and 2, under back-pressure (R8)
    stall = 1; ack_base = 3;
    do_req(1, 1, 3, 4);
    // R3 shared read of modified line fetches from owner 1
    do_req(3, 0, 3, 3);
    drain(); stall = 0; ack_base = 1;
    // R9 owner re-reads its own modified line: no message, still modified
    do_req(1, 0, 7, 2); do_req(1, 1, 7, 4); do_req(1, 0, 7, 9);
    do_req(2, 0, 7, 3);
    drain();
    // R6 owner writeback clears entry; non-owner writeback is ignored
    do_req(0, 2, 9, 6); do_req(0, 1, 9, 4); do_req(0, 2, 9, 6); do_req(2, 1, 9, 6);
    do_req(3, 1, 12, 4); do_req(1, 2, 12, 6); do_req(0, 0, 12, 3);
    do_req(0, 3, 12, 6); do_req(1, 1, 12, 4);
    drain();
    // R5 slow acks plus a stray pulse from an untargeted cache
    do_req(0, 0, 15, 2); do_req(1, 0, 15, 2); do_req(3, 0, 15, 2);
    drain();
    ack_base = 6; stall = 1;
    do_req(2, 1, 15, 5);
    stray = 4'b0100;
    drain();
    stall = 0;
    // R10 all expected grants and messages consumed in order
    checks++;
    if (exp_gnt.size() != 0 || exp_msg.size() != 0) begin
      errors++; $display("FAIL R10 leftover got %0d/%0d exp 0/0", exp_gnt.size(), exp_msg.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule